// File: doc/BRIEF.md
# Start/Done Handshake Arithmetic Unit

This unit combines two unsigned 8-bit operands under a 3-bit opcode and returns a 16-bit result. A requester raises `start` with the operands and opcode already valid. It keeps `start` high until it sees the one-cycle `done` pulse, and then lowers it.

Add, bitwise AND and bitwise XOR finish on the same clock edge that first samples `start`. Multiply takes a fixed number of edges, set by a parameter. The operands are captured when the request is accepted, so the requester may change them while a multiply is in progress.

Two kinds of request never produce `done`: a no-operation request and a request with an unassigned code. Either one can be followed by a new request on the very next edge. A dedicated clear opcode zeroes the result without a completion. A synchronous active-low reset returns the unit to idle and can abort a multiply.

Top module: `tinyalu_hs`

## Requirements
- R1: Opcodes 001 (add, A+B), 010 (AND, A&B) and 011 (XOR, A^B) produce their zero-extended 16-bit result. `done` is high in the cycle right after the edge that first samples `start` high.
- R2: Opcode 100 produces the 16-bit product A*B. With the default MUL_LAT=3, `done` rises on the third edge, counting the sampling edge as the first. It stays low before that.
- R3: `done` is high for exactly one cycle per completion.
- R4: Operands and opcode are taken on the accepting edge. Later changes to them before `done` do not alter the result.
- R5: `start` is ignored while a multiply is in progress and on the edge that immediately follows a `done` pulse.
- R6: Opcodes 000, 101 and 110 never raise `done` and leave `result` unchanged. A new request is accepted on the next edge.
- R7: Opcode 111 sets `result` to zero and does not raise `done`.
- R8: While `rst_n` is low on a clock edge, `done` and `result` go to zero and the unit becomes idle, aborting any multiply in progress.
- R9: Between completions, clear requests and resets, `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request valid, held until `done` is seen |
| opcode | input | 3 | Operation select |
| opnd_a | input | 8 | First unsigned operand |
| opnd_b | input | 8 | Second unsigned operand |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Result of the last completed operation |

## Verification
Add, AND and XOR results and `done` are due right after the edge that samples `start`. A multiply is due MUL_LAT-1 edges later, and a clear shows zero after that same first edge. The bench's behavioural model advances on every rising edge using the inputs present at that edge. Outputs are compared a quarter period later, once every register on the path has settled.

For each waited request, the bench also counts the edges until `done` and compares the count with the expected latency. Operand changes during a multiply, a late drop of `start`, back-to-back silent requests and a reset during a multiply are all driven on falling edges, so the model and the unit see the same values.

// File: rtl/tinyalu_pkg.sv
`timescale 1ns/1ps
package tinyalu_pkg;
  localparam logic [2:0] OPC_NOP = 3'b000;
  localparam logic [2:0] OPC_ADD = 3'b001;
  localparam logic [2:0] OPC_AND = 3'b010;
  localparam logic [2:0] OPC_XOR = 3'b011;
  localparam logic [2:0] OPC_MUL = 3'b100;
  localparam logic [2:0] OPC_CLR = 3'b111;

  typedef enum logic [1:0] {CLS_NONE, CLS_FAST, CLS_SLOW, CLS_CLR} op_class_t;
  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_ACK} state_t;
endpackage

// File: rtl/alu_op_decode.sv
`timescale 1ns/1ps
module alu_op_decode
  import tinyalu_pkg::*;
(
  input  logic [2:0] opcode,
  output op_class_t  cls
);
  always_comb begin
    case (opcode)
      OPC_ADD, OPC_AND, OPC_XOR: cls = CLS_FAST;
      OPC_MUL:                   cls = CLS_SLOW;
      OPC_CLR:                   cls = CLS_CLR;
      default:                   cls = CLS_NONE;  // no-op and unassigned codes
    endcase
  end
endmodule

// File: rtl/alu_seq_ctrl.sv
`timescale 1ns/1ps
module alu_seq_ctrl
  import tinyalu_pkg::*;
#(
  parameter int MUL_LAT = 3  // edges for a multiply, counting the accepting edge; at least 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  op_class_t cls,
  output logic      accept,
  output logic      fast_fin,
  output logic      mul_fin,
  output logic      clr_cmd,
  output logic      done
);
  localparam int CNT_W = $clog2(MUL_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MUL_LAT - 1);

  state_t           st;
  logic [CNT_W-1:0] cnt;

  assign accept   = (st == ST_IDLE) && start;
  assign fast_fin = accept && (cls == CLS_FAST);
  assign clr_cmd  = accept && (cls == CLS_CLR);
  assign mul_fin  = (st == ST_MUL) && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= fast_fin || mul_fin;
      case (st)
        ST_IDLE: begin
          if (fast_fin) begin
            st <= ST_ACK;
          end else if (accept && cls == CLS_SLOW) begin
            st  <= ST_MUL;
            cnt <= CNT_LOAD;
          end
        end
        ST_MUL: begin
          if (mul_fin) st <= ST_ACK;
          else         cnt <= cnt - CNT_W'(1);
        end
        ST_ACK:  st <= ST_IDLE;  // start ignored on the edge after done
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
  import tinyalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            opcode,
  input  logic [DATA_W-1:0]     opnd_a,
  input  logic [DATA_W-1:0]     opnd_b,
  input  logic                  cap,
  input  logic                  fast_fin,
  input  logic                  mul_fin,
  input  logic                  clr_cmd,
  output logic [2*DATA_W-1:0]   result
);
  localparam int RES_W = 2 * DATA_W;

  logic [DATA_W-1:0] a_q, b_q;
  logic [RES_W-1:0]  fast_val;
  logic [RES_W-1:0]  prod;

  always_comb begin
    case (opcode)
      OPC_ADD: fast_val = RES_W'(opnd_a) + RES_W'(opnd_b);
      OPC_AND: fast_val = RES_W'(opnd_a & opnd_b);
      OPC_XOR: fast_val = RES_W'(opnd_a ^ opnd_b);
      default: fast_val = '0;
    endcase
  end

  assign prod = RES_W'(a_q) * RES_W'(b_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (cap) begin
      a_q <= opnd_a;
      b_q <= opnd_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_cmd) result <= '0;
    else if (fast_fin)     result <= fast_val;
    else if (mul_fin)      result <= prod;
  end
endmodule

// File: rtl/tinyalu_hs.sv
`timescale 1ns/1ps
module tinyalu_hs
  import tinyalu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MUL_LAT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          opcode,
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  output logic                done,
  output logic [2*DATA_W-1:0] result
);
  op_class_t cls;
  logic      accept, fast_fin, mul_fin, clr_cmd;

  alu_op_decode u_dec (
    .opcode (opcode),
    .cls    (cls)
  );

  alu_seq_ctrl #(.MUL_LAT(MUL_LAT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cls      (cls),
    .accept   (accept),
    .fast_fin (fast_fin),
    .mul_fin  (mul_fin),
    .clr_cmd  (clr_cmd),
    .done     (done)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .cap      (accept),
    .fast_fin (fast_fin),
    .mul_fin  (mul_fin),
    .clr_cmd  (clr_cmd),
    .result   (result)
  );
endmodule

// File: rtl/tinyalu_hs_chk.sv
`timescale 1ns/1ps
module tinyalu_hs_chk
  import tinyalu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MUL_LAT = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          opcode,
  input logic [DATA_W-1:0]   opnd_a,
  input logic [DATA_W-1:0]   opnd_b,
  input logic                accept,
  input logic                done,
  input logic [2*DATA_W-1:0] result
);
  localparam int RES_W = 2 * DATA_W;

  logic [RES_W-1:0] want_fast;
  logic [RES_W-1:0] prod_q;
  int unsigned      mcnt;
  logic             is_fast, is_silent;

  always_comb begin
    case (opcode)
      OPC_ADD: want_fast = RES_W'(opnd_a) + RES_W'(opnd_b);
      OPC_AND: want_fast = RES_W'(opnd_a & opnd_b);
      OPC_XOR: want_fast = RES_W'(opnd_a ^ opnd_b);
      default: want_fast = '0;
    endcase
  end

  assign is_fast   = (opcode == OPC_ADD) || (opcode == OPC_AND) || (opcode == OPC_XOR);
  assign is_silent = (opcode == 3'b000) || (opcode == 3'b101) || (opcode == 3'b110);

  // counts edges since a multiply was accepted; equals MUL_LAT when done is due
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt   <= 0;
      prod_q <= '0;
    end else if (accept && opcode == OPC_MUL) begin
      mcnt   <= 1;
      prod_q <= RES_W'(opnd_a) * RES_W'(opnd_b);
    end else if (done) begin
      mcnt <= 0;
    end else if (mcnt != 0) begin
      mcnt <= mcnt + 1;
    end
  end

  assert_fast_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_fast) |=> (done && result == $past(want_fast)));

  assert_mul_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt != 0 && mcnt < MUL_LAT) |-> !done);

  assert_mul_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt == MUL_LAT) |-> done);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_mul_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt == MUL_LAT) |-> (result == prod_q));

  assert_no_accept_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !accept);

  assert_no_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt != 0) |-> !accept);

  assert_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_silent) |=> (!done && $stable(result)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode == OPC_CLR) |=> (!done && result == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (done || result == '0));
endmodule

bind tinyalu_hs tinyalu_hs_chk #(.DATA_W(DATA_W), .MUL_LAT(MUL_LAT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .opcode (opcode),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .accept (accept),
  .done   (done),
  .result (result)
);

// File: tb/tinyalu_hs_test.sv
`timescale 1ns/1ps
module tinyalu_hs_test;
  localparam int CLK_P   = 10;
  localparam int MUL_LAT = 3;
  localparam int WD_CYC  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opcode = 3'b000;
  logic [7:0]  opnd_a = 8'h00;
  logic [7:0]  opnd_b = 8'h00;
  logic        done;
  logic [15:0] result;

  int    n_chk = 0;
  int    n_err = 0;
  bit    reported = 0;
  string cur_req = "R8";

  // reference model state
  logic        m_done = 1'b0;
  logic [15:0] m_res = '0;
  logic [15:0] m_prod = '0;
  int          m_left = 0;
  bit          m_hold = 0;
  bit          nd;

  tinyalu_hs #(.DATA_W(8), .MUL_LAT(MUL_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .done(done), .result(result)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // model steps on each rising edge, comparison a quarter period later
  always @(posedge clk) begin
    nd = 1'b0;
    if (!rst_n) begin
      m_res = '0; m_left = 0; m_hold = 0;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) begin nd = 1'b1; m_res = m_prod; m_hold = 1; end
    end else if (m_hold) begin
      m_hold = 0;
    end else if (start) begin
      case (opcode)
        3'b001: begin m_res = 16'(opnd_a) + 16'(opnd_b); nd = 1'b1; m_hold = 1; end
        3'b010: begin m_res = {8'h00, opnd_a & opnd_b};   nd = 1'b1; m_hold = 1; end
        3'b011: begin m_res = {8'h00, opnd_a ^ opnd_b};   nd = 1'b1; m_hold = 1; end
        3'b100: begin m_prod = 16'(opnd_a) * 16'(opnd_b); m_left = MUL_LAT - 1; end
        3'b111: m_res = '0;
        default: ;
      endcase
    end
    m_done = nd;
    #(CLK_P/4);
    chk({cur_req, " done"}, 32'(done), 32'(m_done));
    chk({cur_req, " result"}, 32'(result), 32'(m_res));
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    report();
  end

  function automatic logic [7:0] pick_val();
    case ($urandom % 4)
      0:       return 8'h00;
      3:       return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  // chg: alter inputs while a multiply is pending; late: hold start one extra edge after done
  task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input bit chg, input bit late);
    int  n;
    bit  got;
    bit  waits;
    @(negedge clk);
    opcode = op; opnd_a = a; opnd_b = b; start = 1'b1;
    waits = (op == 3'b001) || (op == 3'b010) || (op == 3'b011) || (op == 3'b100);
    n = 0; got = 0;
    if (!waits) begin
      @(posedge clk); #(CLK_P/4);
      chk({cur_req, " silent no done"}, 32'(done), 32'd0);
      return;
    end
    while (!got && n < 20) begin
      @(posedge clk); #(CLK_P/4);
      n++;
      if (done) got = 1;
      else if (chg && n == 1) begin
        @(negedge clk);
        opnd_a = ~a; opnd_b = b + 8'd1; opcode = 3'b001;
      end
    end
    chk({cur_req, " latency"}, 32'(n), (op == 3'b100) ? 32'(MUL_LAT) : 32'd1);
    @(negedge clk);
    if (late) @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset done", 32'(done), 32'd0);
    chk("R8 reset result", 32'(result), 32'd0);
    rst_n = 1'b1;

    cur_req = "R1";
    do_op(3'b001, 8'hFF, 8'hFF, 0, 0);
    do_op(3'b010, 8'hA5, 8'h3C, 0, 0);
    do_op(3'b011, 8'hA5, 8'hFF, 0, 0);
    do_op(3'b001, 8'h00, 8'h00, 0, 0);

    cur_req = "R2";
    do_op(3'b100, 8'hFF, 8'hFF, 0, 0);
    do_op(3'b100, 8'h00, 8'h37, 0, 0);
    do_op(3'b100, 8'h12, 8'h34, 0, 0);

    cur_req = "R4";
    do_op(3'b100, 8'hC3, 8'h5A, 1, 0);

    cur_req = "R5";
    do_op(3'b011, 8'h0F, 8'hF0, 0, 1);
    do_op(3'b100, 8'h07, 8'h09, 0, 1);

    cur_req = "R6";
    do_op(3'b000, 8'h11, 8'h22, 0, 0);
    do_op(3'b101, 8'h33, 8'h44, 0, 0);
    do_op(3'b110, 8'h55, 8'h66, 0, 0);
    do_op(3'b001, 8'h01, 8'h02, 0, 0);
    cur_req = "R9";
    repeat (3) @(negedge clk);
    chk("R9 held result", 32'(result), 32'h0003);

    cur_req = "R7";
    do_op(3'b111, 8'hFF, 8'hFF, 0, 0);
    @(negedge clk); start = 1'b0;
    chk("R7 cleared result", 32'(result), 32'd0);

    cur_req = "R8";
    do_op(3'b001, 8'h40, 8'h40, 0, 0);
    @(negedge clk);
    opcode = 3'b100; opnd_a = 8'h10; opnd_b = 8'h10; start = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 aborted multiply result", 32'(result), 32'd0);

    cur_req = "R3";
    for (int i = 0; i < 300; i++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      do_op(op, pick_val(), pick_val(), (op == 3'b100) && ($urandom % 4 == 0), ($urandom % 4 == 0));
    end
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    report();
  end
endmodule